// File: doc/BRIEF.md
# Page Table Refill Walker

On a soft translation miss this block walks a one-word page table in physical memory and turns the entry it finds into two hardware map entries. A request gives the faulting 18-bit virtual word address, together with its mode and cycle flags. The walker chooses one of four table base addresses from the mode and the address's top bit, and adds a six-bit index taken from the address. It then reads the table word. The word holds two 18-bit entries, and one address bit picks which of the two applies.

A two-bit access code in the chosen entry decides the outcome. If the access is refused, the walker raises a one-cycle fault pulse and presents a fault word. If the access is allowed, it writes the table word back to the same address with that entry's age bit cleared. It then issues two map loads, the first for the even half-page and the second for the odd half-page, and finally raises a one-cycle done pulse.

The walk is a state machine with these states: `ST_IDLE` → `ST_FETCH` (read held until acknowledged) → `ST_CHECK` → either `ST_FAULT` → `ST_IDLE`, or `ST_WBACK` (write held until acknowledged) → `ST_MAP_EVEN` → `ST_MAP_ODD` → `ST_DONE` → `ST_IDLE`.

Top module: `ptw_refill`

## Requirements
- R1: A request with `req_wtest` high is handled exactly as a write request with `req_write` high. This covers the access check and the write flag in the fault word.
- R2: The table address is the selected base plus the zero-extended index `req_vaddr[16:11]`. The read is issued on `mem_addr` with `mem_we` low.
- R3: Base selection uses `{req_user, req_vaddr[17]}`: 10 selects `base_user_lo`, 11 selects `base_user_hi`, 01 selects `base_exec_hi`, and 00 selects `base_exec_lo`.
- R4: When `req_vaddr[10]` is 1, the entry is bits [17:0] of the table word. When it is 0, the entry is bits [35:18].
- R5: Entry bits [17:16] are the access code. Code 00 always faults and records code 0. Code 01 (read-only) records 1. Code 10 (write-first) records 2 and behaves as read-only. Code 11 (read/write) never faults and marks the mapping writable.
- R6: A code 01 or 10 entry faults when the request is a write. Otherwise it is mapped with the writable bit cleared.
- R7: On success only, the table word is written back to the address it was read from. Entry bit 13 (the age bit) is cleared in the selected half, and every other bit is unchanged. A fault causes no write.
- R8: The map entry has bit 17 = 1 (valid), bit 14 = writable, and bit 13 = entry bit 12 (cache). Bits [10:1] hold entry bits [9:0], and bit 0 is the half-page select. All other bits are 0.
- R9: Two map loads occur in consecutive cycles. The first has `map_vaddr` equal to the request address with bit 9 cleared and `map_entry[0]`=0. The second has bit 9 set and `map_entry[0]`=1. `map_user` equals the request's user flag.
- R10: `walk_done` pulses for one cycle, in the cycle after the odd map load. A refused walk instead pulses `walk_fault` for one cycle, which is never together with `walk_done`. During that pulse `fault_word` = {user[35], write[34], physical[33], recorded code[32:31], `req_addr_hi`[30:27], zeros[26:18], virtual address[17:0]}.
- R11: `busy` is high from the cycle after an accepted request until the walk ends. A `req_valid` seen while busy is ignored. Out of reset the block is idle with every strobe low.
- R12: A memory request keeps `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack` is seen, so any acknowledge latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vaddr | input | 18 | Faulting virtual word address |
| req_user | input | 1 | Request came from user mode |
| req_write | input | 1 | Request is a write |
| req_wtest | input | 1 | Request is a write test |
| req_phys | input | 1 | Physical-reference flag, reported in the fault word |
| req_addr_hi | input | 4 | High address flags, reported in the fault word |
| base_user_lo | input | 20 | Table base, user mode, low half of space |
| base_user_hi | input | 20 | Table base, user mode, high half of space |
| base_exec_hi | input | 20 | Table base, exec mode, high half of space |
| base_exec_lo | input | 20 | Table base, exec mode, low half of space |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 36 | Write-back data |
| mem_ack | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | 36 | Read data |
| map_load | output | 1 | Load one hardware map entry |
| map_user | output | 1 | Mode of the map entry |
| map_vaddr | output | 18 | Virtual address of the map entry |
| map_entry | output | 18 | Hardware map entry |
| walk_done | output | 1 | Walk finished with both maps loaded |
| walk_fault | output | 1 | Walk refused |
| fault_word | output | 36 | Fault description, valid with `walk_fault` |

## Verification
Walks are run with all four mode/high-bit combinations, so each base register is distinguished from the others. An index of all ones over a base that carries shows that the sum is a full add and not a bit merge. The entry sits in the right half for some walks and the left half for others, with the unused half all ones, which exposes a swapped half-select or an age clear in the wrong half. Each of the four access codes is tried with reads, plain writes and write tests, so that faults with each recorded code can be told apart from writable and read-only mappings. One walk uses a slow memory and receives a second request in mid-walk; the walk must complete with no trace of the intruder.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WBACK,
        ST_MAP_EVEN,
        ST_MAP_ODD,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_RWF  = 2'b10,
        ACC_RW   = 2'b11
    } acc_code_t;

endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int PA_W  = 20,
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             user,
    input  logic             high,
    input  logic [PA_W-1:0]  base_user_lo,
    input  logic [PA_W-1:0]  base_user_hi,
    input  logic [PA_W-1:0]  base_exec_hi,
    input  logic [PA_W-1:0]  base_exec_lo,
    output logic [PA_W-1:0]  table_addr
);
    localparam int PAD_W = PA_W - IDX_W;

    logic [PA_W-1:0] base;

    // R3: base chosen by mode and top address bit
    always_comb begin
        unique case ({user, high})
            2'b10:   base = base_user_lo;
            2'b11:   base = base_user_hi;
            2'b01:   base = base_exec_hi;
            default: base = base_exec_lo;
        endcase
    end

    // R2: full add of the zero-extended index
    assign table_addr = base + {{PAD_W{1'b0}}, idx};

endmodule

// File: rtl/ptw_entry.sv
module ptw_entry
    import ptw_pkg::*;
#(
    parameter int HALF_W    = 18,
    parameter int AGE_BIT   = 13,
    parameter int CACHE_BIT = 12,
    parameter int PG_W      = 10
) (
    input  logic [2*HALF_W-1:0] word,
    input  logic                right_half,
    input  logic                want_write,
    output logic                deny,
    output logic [1:0]          rec_code,
    output logic [2*HALF_W-1:0] wb_word,
    output logic [HALF_W-1:0]   map_even,
    output logic [HALF_W-1:0]   map_odd
);
    localparam int WORD_W    = 2 * HALF_W;
    localparam int VALID_BIT = HALF_W - 2;

    function automatic logic [HALF_W-1:0] build_mask();
        logic [HALF_W-1:0] m;
        m = '0;
        m[HALF_W-1]    = 1'b1;
        m[AGE_BIT+1]   = 1'b1;
        m[CACHE_BIT+1] = 1'b1;
        for (int i = 1; i <= PG_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [HALF_W-1:0] MAP_MASK = build_mask();

    logic [HALF_W-1:0] ent;
    logic [HALF_W-1:0] staged;
    acc_code_t         code;
    logic              writable;

    // R4: half selection
    assign ent      = right_half ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    assign code     = acc_code_t'(ent[HALF_W-1 -: 2]);
    assign writable = (code == ACC_RW);

    // R5, R6: access decision
    assign deny     = (code == ACC_NONE) || (!writable && want_write);
    assign rec_code = writable ? 2'b00 : ent[HALF_W-1 -: 2];

    // R8: hardware entry shaping
    always_comb begin
        staged            = ent;
        staged[VALID_BIT] = 1'b1;
        staged[AGE_BIT]   = writable;
    end

    assign map_even = (staged << 1) & MAP_MASK;
    assign map_odd  = map_even | HALF_W'(1);

    // R7: age clear in the selected half only
    always_comb begin
        wb_word = word;
        if (right_half) wb_word[AGE_BIT]        = 1'b0;
        else            wb_word[HALF_W+AGE_BIT] = 1'b0;
    end

endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
    import ptw_pkg::*;
#(
    parameter int HALF_W       = 18,
    parameter int PA_W         = 20,
    parameter int IDX_LSB      = 11,
    parameter int IDX_W        = 6,
    parameter int HALF_SEL_BIT = 10,
    parameter int PAIR_BIT     = 9,
    parameter int AGE_BIT      = 13,
    parameter int CACHE_BIT    = 12,
    parameter int PG_W         = 10,
    parameter int HI_W         = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [HALF_W-1:0]     req_vaddr,
    input  logic                  req_user,
    input  logic                  req_write,
    input  logic                  req_wtest,
    input  logic                  req_phys,
    input  logic [HI_W-1:0]       req_addr_hi,
    input  logic [PA_W-1:0]       base_user_lo,
    input  logic [PA_W-1:0]       base_user_hi,
    input  logic [PA_W-1:0]       base_exec_hi,
    input  logic [PA_W-1:0]       base_exec_lo,
    output logic                  busy,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [PA_W-1:0]       mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata,
    input  logic                  mem_ack,
    input  logic [2*HALF_W-1:0]   mem_rdata,
    output logic                  map_load,
    output logic                  map_user,
    output logic [HALF_W-1:0]     map_vaddr,
    output logic [HALF_W-1:0]     map_entry,
    output logic                  walk_done,
    output logic                  walk_fault,
    output logic [2*HALF_W-1:0]   fault_word
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int ZERO_W = HALF_W - 5 - HI_W;

    walk_state_t         state, state_nx;
    logic [HALF_W-1:0]   va_q;
    logic                user_q, wr_q, phys_q;
    logic [HI_W-1:0]     hi_q;
    logic [WORD_W-1:0]   word_q;
    logic [1:0]          rec_q;

    logic [PA_W-1:0]     table_addr;
    logic                deny;
    logic [1:0]          rec_code;
    logic [WORD_W-1:0]   wb_word;
    logic [HALF_W-1:0]   map_even, map_odd;

    ptw_index #(.PA_W(PA_W), .IDX_W(IDX_W)) u_index (
        .idx          (va_q[IDX_LSB +: IDX_W]),
        .user         (user_q),
        .high         (va_q[HALF_W-1]),
        .base_user_lo (base_user_lo),
        .base_user_hi (base_user_hi),
        .base_exec_hi (base_exec_hi),
        .base_exec_lo (base_exec_lo),
        .table_addr   (table_addr)
    );

    ptw_entry #(
        .HALF_W(HALF_W), .AGE_BIT(AGE_BIT), .CACHE_BIT(CACHE_BIT), .PG_W(PG_W)
    ) u_entry (
        .word       (word_q),
        .right_half (va_q[HALF_SEL_BIT]),
        .want_write (wr_q),
        .deny       (deny),
        .rec_code   (rec_code),
        .wb_word    (wb_word),
        .map_even   (map_even),
        .map_odd    (map_odd)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_FETCH;
            ST_FETCH:    if (mem_ack)   state_nx = ST_CHECK;
            ST_CHECK:    state_nx = deny ? ST_FAULT : ST_WBACK;
            ST_WBACK:    if (mem_ack)   state_nx = ST_MAP_EVEN;
            ST_MAP_EVEN: state_nx = ST_MAP_ODD;
            ST_MAP_ODD:  state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            ST_FAULT:    state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request and table-word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            user_q <= 1'b0;
            wr_q   <= 1'b0;
            phys_q <= 1'b0;
            hi_q   <= '0;
            word_q <= '0;
            rec_q  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                user_q <= req_user;
                wr_q   <= req_write | req_wtest;   // R1
                phys_q <= req_phys;
                hi_q   <= req_addr_hi;
            end
            if (state == ST_FETCH && mem_ack) word_q <= mem_rdata;
            if (state == ST_CHECK)            rec_q  <= rec_code;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = table_addr;
        mem_wdata  = wb_word;
        map_load   = 1'b0;
        map_user   = user_q;
        map_vaddr  = va_q;
        map_entry  = map_even;
        walk_done  = 1'b0;
        walk_fault = 1'b0;
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_MAP_EVEN: begin
                map_load            = 1'b1;
                map_vaddr[PAIR_BIT] = 1'b0;
            end
            ST_MAP_ODD: begin
                map_load            = 1'b1;
                map_vaddr[PAIR_BIT] = 1'b1;
                map_entry           = map_odd;
            end
            ST_DONE:  walk_done  = 1'b1;
            ST_FAULT: walk_fault = 1'b1;
            default: ;
        endcase
    end

    assign fault_word = {user_q, wr_q, phys_q, rec_q, hi_q, {ZERO_W{1'b0}}, va_q};

endmodule

// File: rtl/ptw_refill_chk.sv
module ptw_refill_chk #(
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [PA_W-1:0] mem_addr,
    input logic            map_load,
    input logic            map_pair,
    input logic            map_odd_bit,
    input logic            map_valid_bit,
    input logic            walk_done,
    input logic            walk_fault
);
    logic [PA_W-1:0] rd_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                rd_addr_q <= '0;
        else if (mem_req && mem_ack && !mem_we)    rd_addr_q <= mem_addr;
    end

    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_wb_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

    assert_map_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (map_load && !map_pair) |=> (map_load && map_pair));

    assert_map_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        map_load |-> (map_odd_bit == map_pair));

    assert_map_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        map_load |-> map_valid_bit);

    assert_done_after_odd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> ($past(map_load) && $past(map_pair)));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_fault));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !map_load && !walk_done && !walk_fault));

endmodule

bind ptw_refill ptw_refill_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .map_load      (map_load),
    .map_pair      (map_vaddr[PAIR_BIT]),
    .map_odd_bit   (map_entry[0]),
    .map_valid_bit (map_entry[HALF_W-1]),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault)
);

// File: tb/test_ptw_refill.sv
`timescale 1ns/100ps
module test_ptw_refill;

    localparam logic [19:0] B_UL = 20'h01000;
    localparam logic [19:0] B_UH = 20'h02000;
    localparam logic [19:0] B_EH = 20'h03000;
    localparam logic [19:0] B_EL = 20'h0FFE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_vaddr = '0;
    logic        req_user = 1'b0, req_write = 1'b0, req_wtest = 1'b0, req_phys = 1'b0;
    logic [3:0]  req_addr_hi = '0;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [35:0] mem_wdata, mem_rdata, fault_word;
    logic        map_load, map_user, walk_done, walk_fault;
    logic [17:0] map_vaddr, map_entry;

    int checks = 0;
    int fails  = 0;
    int mem_lat = 0;

    logic [35:0] mem [int];

    int          q_kind [$];
    logic [19:0] q_addr [$];
    logic [35:0] q_data [$];
    logic        q_flag [$];
    string       q_tag  [$];

    always #2.5 clk = ~clk;

    ptw_refill i_ptw_refill (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_user(req_user),
        .req_write(req_write), .req_wtest(req_wtest), .req_phys(req_phys),
        .req_addr_hi(req_addr_hi),
        .base_user_lo(B_UL), .base_user_hi(B_UH),
        .base_exec_hi(B_EH), .base_exec_lo(B_EL),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .map_load(map_load), .map_user(map_user), .map_vaddr(map_vaddr),
        .map_entry(map_entry), .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_word(fault_word)
    );

    task automatic push(int k, logic [19:0] a, logic [35:0] d, logic f, string t);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
        q_flag.push_back(f); q_tag.push_back(t);
    endtask

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: acknowledge after mem_lat idle cycles
    initial begin
        int wcnt;
        wcnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (rst_n && mem_req) begin
                if (wcnt >= mem_lat) begin
                    wcnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                    else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
                end else wcnt++;
            end
        end
    end

    // Monitor: compare observed events against the scoreboard queue
    task automatic observe(int k, logic [19:0] a, logic [35:0] d, logic f);
        int ek; logic [19:0] ea; logic [35:0] ed; logic ef; string et;
        if (q_kind.size() == 0) begin
            checks++; fails++;
            $display("FAIL R11 unexpected event kind=%0d actual addr=%h data=%h expected none", k, a, d);
        end else begin
            ek = q_kind.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
            ef = q_flag.pop_front(); et = q_tag.pop_front();
            check(ek == k && ea == a && ed == d && ef == f, et,
                  {4'(k), a, d, 4'(f)}, {4'(ek), ea, ed, 4'(ef)});
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (rst_n) begin
                if (mem_req && mem_ack) observe(mem_we ? 1 : 0, mem_addr, mem_we ? mem_wdata : 36'h0, 1'b0);
                if (map_load)   observe(2, {2'b00, map_vaddr}, {18'h0, map_entry}, map_user);
                if (walk_done)  observe(3, 20'h0, 36'h0, 1'b0);
                if (walk_fault) observe(4, 20'h0, fault_word, 1'b0);
            end
        end
    end

    function automatic logic [17:0] mk_ent(logic [1:0] code, logic age, logic cache, logic [9:0] pg);
        return {code, 2'b00, age, cache, 2'b00, pg};
    endfunction

    function automatic logic [17:0] mk_va(logic hi, logic [5:0] idx, logic half, logic pair, logic [8:0] off);
        return {hi, idx, half, pair, off};
    endfunction

    // Driver: compute expectations from the requirements, push, then stimulate
    task automatic walk(logic [17:0] va, logic user, logic wr, logic wt, logic ph,
                        logic [3:0] hi, logic [17:0] ent, int lat, bit intrude);
        logic [19:0] base, addr;
        logic [35:0] word, wb, fw;
        logic [17:0] other, hw;
        logic [1:0]  code, rec;
        logic        w, deny;
        mem_lat = lat;
        // R3 base selection
        case ({user, va[17]})
            2'b10: base = B_UL;
            2'b11: base = B_UH;
            2'b01: base = B_EH;
            default: base = B_EL;
        endcase
        addr  = base + {14'h0, va[16:11]};                 // R2
        other = 18'h3FFFF;
        word  = va[10] ? {other, ent} : {ent, other};       // R4
        mem[int'(addr)] = word;
        code = ent[17:16];
        w    = wr | wt;                                     // R1
        deny = (code == 2'b00) || (code != 2'b11 && w);     // R5, R6
        rec  = (code == 2'b11) ? 2'b00 : code;
        push(0, addr, 36'h0, 1'b0, "R2 R3 table read address");
        if (deny) begin
            fw = {user, w, ph, rec, hi, 9'h0, va};
            push(4, 20'h0, fw, 1'b0, "R5 R6 R10 fault word");
        end else begin
            wb = word;
            if (va[10]) wb[13] = 1'b0; else wb[31] = 1'b0;
            push(1, addr, wb, 1'b0, "R7 write-back");
            hw = '0;
            hw[17] = 1'b1;
            hw[14] = (code == 2'b11);
            hw[13] = ent[12];
            hw[10:1] = ent[9:0];
            push(2, {2'b00, va & ~18'h200}, {18'h0, hw}, user, "R8 R9 even map load");
            push(2, {2'b00, va | 18'h200}, {18'h0, hw | 18'h1}, user, "R8 R9 odd map load");
            push(3, 20'h0, 36'h0, 1'b0, "R10 done pulse");
        end
        @(negedge clk);
        req_vaddr = va; req_user = user; req_write = wr; req_wtest = wt;
        req_phys = ph; req_addr_hi = hi; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            @(negedge clk);
            #1;
            check(busy == 1'b1, "R11 busy during walk", {63'h0, busy}, 64'h1);
            req_vaddr = ~va; req_user = ~user; req_write = 1'b1; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #1;
            if (!busy && q_kind.size() == 0) break;
        end
        check(!busy && q_kind.size() == 0, "R10 R11 walk completed and idle",
              {32'(q_kind.size()), 31'h0, busy}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !mem_req && !map_load && !walk_done && !walk_fault,
              "R11 reset state", {59'h0, busy, mem_req, map_load, walk_done, walk_fault}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // user low, right half, read/write, read
        walk(mk_va(0, 6'd5, 1, 0, 9'h012), 1, 0, 0, 0, 4'h3, mk_ent(2'b11, 1, 1, 10'h2A5), 0, 0);
        // user high, left half, read-only, read
        walk(mk_va(1, 6'h21, 0, 1, 9'h1F0), 1, 0, 0, 0, 4'h0, mk_ent(2'b01, 1, 0, 10'h155), 1, 0);
        // exec high, right half, write-first, read
        walk(mk_va(1, 6'd7, 1, 1, 9'h003), 0, 0, 0, 1, 4'h1, mk_ent(2'b10, 0, 1, 10'h3FF), 0, 0);
        // exec low with carrying index, left half, read/write, write
        walk(mk_va(0, 6'h3F, 0, 0, 9'h100), 0, 1, 0, 0, 4'h2, mk_ent(2'b11, 0, 0, 10'h001), 2, 0);
        // R6: read-only with write faults, records code 1
        walk(mk_va(0, 6'd9, 1, 0, 9'h044), 1, 1, 0, 0, 4'h5, mk_ent(2'b01, 1, 1, 10'h0F0), 0, 0);
        // R1: write test on write-first faults, records code 2
        walk(mk_va(1, 6'd11, 0, 1, 9'h0AA), 0, 0, 1, 1, 4'hA, mk_ent(2'b10, 1, 0, 10'h200), 1, 0);
        // R5: not accessible on read, records code 0
        walk(mk_va(0, 6'd13, 1, 1, 9'h155), 1, 0, 0, 0, 4'hF, mk_ent(2'b00, 1, 1, 10'h0AB), 0, 0);
        // R1: write test on read/write entry is mapped writable
        walk(mk_va(1, 6'd17, 1, 0, 9'h0FF), 1, 0, 1, 0, 4'h4, mk_ent(2'b11, 1, 0, 10'h3C3), 0, 0);
        // R11 R12: slow memory with a request arriving mid-walk
        walk(mk_va(0, 6'd19, 0, 1, 9'h1A1), 1, 0, 0, 0, 4'h6, mk_ent(2'b11, 1, 1, 10'h066), 4, 1);
        // R6: read-only on read after the intrusion, exec low
        walk(mk_va(0, 6'd2, 1, 0, 9'h010), 0, 0, 0, 0, 4'h7, mk_ent(2'b01, 0, 1, 10'h111), 0, 0);

        repeat (4) @(negedge clk);
        check(q_kind.size() == 0, "R10 no pending expected events", 64'(q_kind.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule